// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path. It watches the first six bytes of each incoming frame (the destination address), one byte per accepted beat. After the sixth byte it decides whether the frame is kept and whether it is flagged as an address miss. Downstream logic uses the decision to store or drop the payload. The payload itself is not handled here.

Each destination falls into one of three classes. An all-ones address is a broadcast and is governed by a reject mode bit. An address with bit 0 of its first byte set (group address) goes through a 64-entry hash table. When the hash-all mode bit is set, every non-broadcast address also goes through the hash table. All other addresses are compared against the programmed station address. The hash index comes from a CRC-32 that is computed serially as the bytes arrive, so no extra cycles are spent after the last byte.

In promiscuous mode a miss does not drop the frame: the frame is accepted and the miss flag is set. A frame that ends before its sixth byte is treated as a miss.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, and in every cycle without a decision, `dec_valid`, `dec_accept` and `dec_miss` are all 0.
- R2: A decision pulses `dec_valid` high for exactly one cycle, in the cycle after the clock edge that captures the sixth address byte. Bytes that arrive after the sixth byte and before the next `byte_first` produce no further decision.
- R3: An all-ones destination address (six bytes of 0xFF) is a broadcast. It is a miss exactly when `mode_bcast_reject` is 1, regardless of the hash table and the station address.
- R4: A non-broadcast address uses the hash table when bit 0 of its first byte is 1, or when `mode_hash_all` is 1. Otherwise it uses the station address comparison.
- R5: The hash CRC starts at 0xFFFFFFFF and takes each byte least significant bit first. For each bit, carry = crc[31] XOR data bit; the CRC then shifts left by one; if carry is 1 the CRC is XORed with 0x04C11DB6 and bit 0 is forced to 1. The index is bits 31:26 of the CRC after six bytes. Indices 0 to 31 select that bit of `hash_lo`, indices 32 to 63 select bit (index-32) of `hash_hi`. A set bit is a hit; a clear bit is a miss.
- R6: In the station comparison, byte 0 must equal `addr_hi[15:8]`, byte 1 `addr_hi[7:0]`, byte 2 `addr_lo[31:24]`, byte 3 `addr_lo[23:16]`, byte 4 `addr_lo[15:8]` and byte 5 `addr_lo[7:0]`. Any unequal byte is a miss.
- R7: `dec_accept` is 1 for a non-miss. For a miss it equals `mode_promisc`, and `dec_miss` is 1.
- R8: If `frame_end` is seen after fewer than six address bytes of a frame, the next cycle reports `dec_valid`=1 and `dec_miss`=1, with `dec_accept` equal to `mode_promisc`.
- R9: The CRC and the match state restart at every `byte_first`, so a frame's decision does not depend on any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | A frame byte is present this cycle |
| byte_first | input | 1 | With byte_valid: first byte of a new frame |
| byte_data | input | 8 | Frame byte |
| frame_end | input | 1 | The current frame has ended |
| addr_hi | input | 16 | Station address bytes 0 and 1 |
| addr_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash table entries 0 to 31 |
| hash_hi | input | 32 | Hash table entries 32 to 63 |
| mode_bcast_reject | input | 1 | Treat broadcast as a miss |
| mode_hash_all | input | 1 | Send every non-broadcast address through the hash table |
| mode_promisc | input | 1 | Accept misses and flag them |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Address did not match |

## Verification
A stale or wrong CRC register shows up as the wrong hit or miss on the very next group-address decision. Because the index depends on all 48 bits, sweeping several addresses with the target hash bit set and cleared catches a wrong polynomial, a wrong bit order or a missed restart within one frame. A wrong byte counter shows at the ports as a decision strobe one cycle early or late, or as an extra strobe on trailing bytes. A wrong station-byte mapping flips the miss flag for the one frame whose corrupted byte lands on the mis-wired comparison, which the sweep of single-byte corruptions exposes.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter logic [31:0] HASH_POLY = 32'h04C11DB6,
  parameter logic [31:0] CRC_SEED  = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        byte_first,
  input  logic [7:0]  byte_data,
  input  logic        frame_end,
  input  logic [15:0] addr_hi,
  input  logic [31:0] addr_lo,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  input  logic        mode_bcast_reject,
  input  logic        mode_hash_all,
  input  logic        mode_promisc,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_miss
);
  localparam int ALEN = 6;
  localparam int CW   = $clog2(ALEN + 1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        cy;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      cy = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (cy) c = (c ^ HASH_POLY) | 32'h1;
    end
    return c;
  endfunction

  logic [CW-1:0] cnt;
  logic          busy;
  logic [31:0]   crc;
  logic          all_ff, grp, uc_ok;

  logic [CW-1:0] pos;
  logic [31:0]   crc_nx;
  logic [7:0]    ref_byte;
  logic          ff_nx, grp_nx, uc_nx, hit, miss_full;

  wire take  = byte_valid && (byte_first || (busy && cnt < CW'(ALEN)));
  wire last  = take && pos == CW'(ALEN - 1);
  wire short_end = frame_end && !last && (busy || take);

  assign pos = byte_first ? '0 : cnt;

  always_comb begin
    case (pos)
      CW'(0):  ref_byte = addr_hi[15:8];
      CW'(1):  ref_byte = addr_hi[7:0];
      CW'(2):  ref_byte = addr_lo[31:24];
      CW'(3):  ref_byte = addr_lo[23:16];
      CW'(4):  ref_byte = addr_lo[15:8];
      default: ref_byte = addr_lo[7:0];
    endcase
  end

  assign crc_nx = crc_byte(byte_first ? CRC_SEED : crc, byte_data);
  assign ff_nx  = (byte_first || all_ff) && byte_data == 8'hFF;
  assign grp_nx = byte_first ? byte_data[0] : grp;
  assign uc_nx  = (byte_first || uc_ok) && byte_data == ref_byte;
  assign hit    = crc_nx[31] ? hash_hi[crc_nx[30:26]] : hash_lo[crc_nx[30:26]];

  always_comb begin
    if (ff_nx)                        miss_full = mode_bcast_reject;
    else if (grp_nx || mode_hash_all) miss_full = !hit;
    else                              miss_full = !uc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      crc    <= CRC_SEED;
      all_ff <= 1'b0;
      grp    <= 1'b0;
      uc_ok  <= 1'b0;
    end else begin
      if (take) begin
        cnt    <= pos + CW'(1);
        crc    <= crc_nx;
        all_ff <= ff_nx;
        grp    <= grp_nx;
        uc_ok  <= uc_nx;
      end
      if (last || short_end) busy <= 1'b0;
      else if (take)         busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid  <= last || short_end;
      dec_miss   <= last ? miss_full : short_end;
      dec_accept <= last ? (!miss_full || mode_promisc) : (short_end && mode_promisc);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_miss));

  assert_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid || frame_end));

  assert_hit_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_miss) |-> dec_accept);

  assert_miss_kept_only_promisc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_miss && dec_accept) |-> $past(mode_promisc));

  assert_short_is_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_end && !byte_valid) |=> (dec_valid && dec_miss));
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0, byte_first = 1'b0, frame_end = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [15:0] addr_hi = 16'h021A;
  logic [31:0] addr_lo = 32'h3C5E7091;
  logic [31:0] hash_lo = 32'h0, hash_hi = 32'h0;
  logic        mode_bcast_reject = 1'b0, mode_hash_all = 1'b0, mode_promisc = 1'b0;
  logic        dec_valid, dec_accept, dec_miss;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .frame_end(frame_end), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .mode_bcast_reject(mode_bcast_reject),
    .mode_hash_all(mode_hash_all), .mode_promisc(mode_promisc),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss));

  task automatic check(input bit ok, input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got valid/accept/miss=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] v = a[47 - 8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        logic top = r[31];
        r = r << 1;
        if (top != v[k]) r = (r ^ 32'h04C11DB6) | 32'h1;
      end
    end
    return r[31:26];
  endfunction

  function automatic bit ref_miss(input logic [47:0] a);
    logic [63:0] tab = {hash_hi, hash_lo};
    if (a == {48{1'b1}}) return mode_bcast_reject;
    if (a[40] || mode_hash_all) return !tab[ref_index(a)];
    return a != {addr_hi, addr_lo};
  endfunction

  task automatic send_addr(input logic [47:0] a, input int trailing, input string req);
    bit m;
    logic [2:0] exp;
    m = ref_miss(a);
    exp = {1'b1, !m || mode_promisc, m};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k > 0) check(dec_valid == 1'b0, "R2", {dec_valid, dec_accept, dec_miss}, 3'b000);
      byte_valid = 1'b1;
      byte_first = (k == 0);
      byte_data  = a[47 - 8*k -: 8];
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_first = 1'b0;
    check({dec_valid, dec_accept, dec_miss} == exp, req, {dec_valid, dec_accept, dec_miss}, exp);
    for (int k = 0; k < trailing; k++) begin
      byte_valid = 1'b1;
      byte_data  = 8'h55;
      @(negedge clk);
      check(dec_valid == 1'b0, "R2 trailing", {dec_valid, dec_accept, dec_miss}, 3'b000);
    end
    byte_valid = 1'b0;
    @(negedge clk);
    check(dec_valid == 1'b0, "R2 single pulse", {dec_valid, dec_accept, dec_miss}, 3'b000);
  endtask

  task automatic send_short(input logic [47:0] a, input int n);
    logic [2:0] exp = {1'b1, mode_promisc, 1'b1};
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_first = (k == 0);
      byte_data  = a[47 - 8*k -: 8];
      frame_end  = (k == n - 1);
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_first = 1'b0; frame_end = 1'b0;
    check({dec_valid, dec_accept, dec_miss} == exp, "R8 short frame",
          {dec_valid, dec_accept, dec_miss}, exp);
    @(negedge clk);
  endtask

  initial begin
    logic [47:0] station, mc0, mc1, a;
    logic [63:0] tab;
    logic [5:0]  idx;
    station = {16'h021A, 32'h3C5E7091};
    mc0 = 48'h01005E0000FB;
    mc1 = 48'h333300000001;
    repeat (3) @(negedge clk);
    check({dec_valid, dec_accept, dec_miss} == 3'b000, "R1 reset", {dec_valid, dec_accept, dec_miss}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check({dec_valid, dec_accept, dec_miss} == 3'b000, "R1 idle", {dec_valid, dec_accept, dec_miss}, 3'b000);

    for (int m = 0; m < 8; m++) begin
      mode_bcast_reject = m[0];
      mode_hash_all     = m[1];
      mode_promisc      = m[2];
      {hash_hi, hash_lo} = 64'h5A5A_0F0F_A5A5_F0F0;
      send_addr({48{1'b1}}, 0, "R3 broadcast");
      {hash_hi, hash_lo} = 64'h0;
      send_addr({48{1'b1}}, 0, "R3 broadcast empty table");
      send_addr(station, 0, "R4/R6 station");
      idx = ref_index(station);
      {hash_hi, hash_lo} = 64'h1 << idx;
      send_addr(station, 0, "R4 station via hash");
      {hash_hi, hash_lo} = 64'h0;
      for (int b = 0; b < 6; b++) begin
        a = station ^ (48'h02 << (8 * (5 - b)));
        send_addr(a, 0, "R6 byte mismatch");
      end
      foreach (mc0[i]) begin end
      for (int v = 0; v < 2; v++) begin
        a = v ? mc1 : mc0;
        idx = ref_index(a);
        tab = 64'hC3C3_3C3C_9696_6969 | (64'h1 << idx);
        {hash_hi, hash_lo} = tab;
        send_addr(a, 0, "R5 hash hit");
        send_addr(a, 0, "R9 repeated frame");
        {hash_hi, hash_lo} = tab & ~(64'h1 << idx);
        send_addr(a, 0, "R5 hash miss");
        {hash_hi, hash_lo} = ~(64'h1 << idx);
        send_addr(a, 0, "R5 hash miss full table");
      end
      send_addr(station, 3, "R2 trailing bytes");
    end

    for (int p = 0; p < 2; p++) begin
      mode_promisc = p[0];
      mode_bcast_reject = 1'b0;
      mode_hash_all = 1'b0;
      for (int n = 1; n < 6; n++) send_short(station, n);
      send_addr(station, 0, "R9 after short frame");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule